// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single host requests into the bus cycles of an 8-bit NAND or xD flash device. Each request names one of four operations: a command latch, a three-byte address phase, a data write, or a data read. The sequencer drives chip enable, the command and address latch enables, the write and read strobes, and the data bus output and its enable. It also watches the ready/busy line. All timing is counted in clock cycles. The strobe low width and the high-hold width each come from their own configuration input.

A request is accepted with a valid/ready handshake, and only in the idle state. Opcode encoding on `req_op`: 0 = command, 1 = three-byte address, 2 = write, 3 = read. When the operation finishes, the block raises `done` for one cycle. For a read, `rd_data` then holds the captured byte, or `rd_err` is set if the ready line stayed low past the timeout. Setting `hold_ce` keeps chip enable asserted between requests, so a whole flash transaction can be built from a chain of requests.

The controller states are IDLE (waiting for a request), SETUP (one clock with chip enable and the latch enables set), WAIT_RDY (a read waiting for ready), STROBE (WE# or RE# low), HOLD (strobe high, hold time running) and FINISH (done pulse). The transitions are: IDLE→SETUP on accept; SETUP→WAIT_RDY for a read, otherwise SETUP→STROBE; WAIT_RDY→STROBE when ready is high; WAIT_RDY→FINISH on timeout; STROBE→HOLD when the pulse count ends; HOLD→STROBE for the next address byte; HOLD→FINISH after the last byte; FINISH→IDLE.

Top module: `nand_cycle_seq`

## Requirements
- R1: While reset is held and after its release, the block is idle: ce_n, we_n and re_n are high, cle, ale, dq_oe and done are low, and req_ready is high.
- R2: Every WE# or RE# low pulse lasts exactly cfg_pulse clocks.
- R3: After each strobe pulse the strobe stays high for cfg_hold clocks. A CMD or WRITE raises done cfg_pulse+cfg_hold+2 clock samples after it is accepted.
- R4: A CMD (opcode 0) holds CE# low and CLE high from before WE# falls until after WE# rises. ALE stays low and the bus carries req_data.
- R5: An ADDR3 (opcode 1) keeps ALE high and CLE low and issues three WE# strobes. Their bytes are req_data, then req_page[7:0], then req_page[15:8]. done follows 3*(pulse+hold)+2 samples after accept.
- R6: A WRITE (opcode 2) drives req_data with dq_oe high for every clock that WE# is low.
- R7: A READ (opcode 3) does not drive RE# low until the ready line is high. rd_data returns the byte on dq_in at the end of the RE# pulse, with rd_err low.
- R8: dq_oe is low whenever RE# is low.
- R9: A cfg_pulse or cfg_hold value of 0 acts as 1.
- R10: A READ that sees ready low for cfg_timeout consecutive clocks finishes with rd_err high and no RE# pulse.
- R11: When hold_ce was set with a request, CE# stays low after done. When it was clear, CE# is high in the done cycle and in the idle state that follows.
- R12: req_ready is low from accept to the done cycle. done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | Operation: 0 CMD, 1 ADDR3, 2 WRITE, 3 READ |
| req_data | input | 8 | Command, write byte or column byte |
| req_page | input | 16 | Page bytes for ADDR3, low byte first |
| hold_ce | input | 1 | Keep CE# low after this request |
| cfg_pulse | input | 4 | Strobe low width in clocks |
| cfg_hold | input | 4 | Strobe high-hold width in clocks |
| cfg_timeout | input | 16 | Ready wait limit in clocks |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| rd_err | output | 1 | Last read timed out |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | 8 | Data bus output value |
| fl_dq_oe | output | 1 | Data bus output enable |
| fl_dq_in | input | 8 | Data bus input value |
| fl_rdy | input | 1 | Ready/busy line, high when ready |

## Verification
The hardest state to reach from the ports is a read that sits in WAIT_RDY across many clocks. The test has to show that RE# stays high for that whole stretch and then drops only once ready rises. The bench holds the ready line low before it issues the read. A parallel thread releases ready a fixed number of clocks later, while a monitor flags any RE# low sample taken while ready is low. A second read keeps ready low for good, with a short limit, so that the timeout path finishes with the error flag and no strobe.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR3 = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } nand_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_WAIT_RDY,
        S_STROBE,
        S_HOLD,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > W'(1)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/nand_busy_watch.sv
module nand_busy_watch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign expired = run && (cnt_q >= (limit - W'(1)));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TW    = 4,
    parameter int TOW   = 16,
    parameter int NADDR = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [DW-1:0]           req_data,
    input  logic [(NADDR-1)*DW-1:0] req_page,
    input  logic                    hold_ce,
    input  logic [TW-1:0]           cfg_pulse,
    input  logic [TW-1:0]           cfg_hold,
    input  logic [TOW-1:0]          cfg_timeout,
    output logic                    done,
    output logic [DW-1:0]           rd_data,
    output logic                    rd_err,
    output logic                    fl_ce_n,
    output logic                    fl_cle,
    output logic                    fl_ale,
    output logic                    fl_we_n,
    output logic                    fl_re_n,
    output logic [DW-1:0]           fl_dq_out,
    output logic                    fl_dq_oe,
    input  logic [DW-1:0]           fl_dq_in,
    input  logic                    fl_rdy
);
    localparam int PW  = (NADDR - 1) * DW;
    localparam int BIW = (NADDR > 1) ? $clog2(NADDR) : 1;
    localparam logic [BIW-1:0] LAST_IDX = BIW'(NADDR - 1);

    seq_state_e     state_q, state_d;
    nand_op_e       op_q;
    logic [DW-1:0]  data_q;
    logic [PW-1:0]  page_q;
    logic [BIW-1:0] idx_q;
    logic           hold_ce_q;
    logic           keep_ce_q;
    logic [DW-1:0]  rd_data_q;
    logic           rd_err_q;

    logic [TW-1:0]  pulse_eff, hold_eff;
    logic [TOW-1:0] tout_eff;
    logic           tmr_load, tmr_last;
    logic [TW-1:0]  tmr_val;
    logic           tout_hit;
    logic           accept;
    logic [DW-1:0]  addr_b [NADDR];

    assign pulse_eff = (cfg_pulse == '0) ? TW'(1) : cfg_pulse;
    assign hold_eff  = (cfg_hold == '0) ? TW'(1) : cfg_hold;
    assign tout_eff  = (cfg_timeout == '0) ? TOW'(1) : cfg_timeout;
    assign accept    = (state_q == S_IDLE) && req_valid;

    assign addr_b[0] = data_q;
    for (genvar g = 1; g < NADDR; g++) begin : g_addr
        assign addr_b[g] = page_q[(g-1)*DW +: DW];
    end

    assign tmr_load = ((state_d == S_STROBE) && (state_q != S_STROBE)) ||
                      ((state_d == S_HOLD) && (state_q != S_HOLD));
    assign tmr_val  = (state_d == S_STROBE) ? pulse_eff : hold_eff;

    nand_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    nand_busy_watch #(.W(TOW)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != S_WAIT_RDY),
        .run     ((state_q == S_WAIT_RDY) && !fl_rdy),
        .limit   (tout_eff),
        .expired (tout_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_SETUP;
            S_SETUP:    state_d = (op_q == OP_READ) ? S_WAIT_RDY : S_STROBE;
            S_WAIT_RDY: begin
                if (fl_rdy)        state_d = S_STROBE;
                else if (tout_hit) state_d = S_FINISH;
            end
            S_STROBE:   if (tmr_last) state_d = S_HOLD;
            S_HOLD: begin
                if (tmr_last) begin
                    if ((op_q == OP_ADDR3) && (idx_q != LAST_IDX)) state_d = S_STROBE;
                    else                                           state_d = S_FINISH;
                end
            end
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            op_q      <= OP_CMD;
            data_q    <= '0;
            page_q    <= '0;
            idx_q     <= '0;
            hold_ce_q <= 1'b0;
            keep_ce_q <= 1'b0;
            rd_data_q <= '0;
            rd_err_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q      <= nand_op_e'(req_op);
                data_q    <= req_data;
                page_q    <= req_page;
                hold_ce_q <= hold_ce;
                idx_q     <= '0;
                rd_err_q  <= 1'b0;
            end
            if ((state_q == S_STROBE) && tmr_last && (op_q == OP_READ)) begin
                rd_data_q <= fl_dq_in;
            end
            if ((state_q == S_HOLD) && tmr_last && (op_q == OP_ADDR3) && (idx_q != LAST_IDX)) begin
                idx_q <= idx_q + BIW'(1);
            end
            if ((state_q == S_WAIT_RDY) && !fl_rdy && tout_hit) begin
                rd_err_q <= 1'b1;
            end
            if (state_q == S_FINISH) begin
                keep_ce_q <= hold_ce_q;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        fl_ce_n   = 1'b0;
        fl_cle    = 1'b0;
        fl_ale    = 1'b0;
        fl_we_n   = 1'b1;
        fl_re_n   = 1'b1;
        fl_dq_oe  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                fl_ce_n   = !keep_ce_q;
            end
            S_SETUP, S_HOLD: begin
                fl_cle   = (op_q == OP_CMD);
                fl_ale   = (op_q == OP_ADDR3);
                fl_dq_oe = (op_q != OP_READ);
            end
            S_WAIT_RDY: begin
                fl_ce_n = 1'b0;
            end
            S_STROBE: begin
                fl_cle   = (op_q == OP_CMD);
                fl_ale   = (op_q == OP_ADDR3);
                fl_dq_oe = (op_q != OP_READ);
                fl_we_n  = (op_q == OP_READ);
                fl_re_n  = (op_q != OP_READ);
            end
            S_FINISH: begin
                done    = 1'b1;
                fl_ce_n = !hold_ce_q;
            end
            default: fl_ce_n = 1'b1;
        endcase
    end

    assign fl_dq_out = (op_q == OP_ADDR3) ? addr_b[idx_q] : data_q;
    assign rd_data   = rd_data_q;
    assign rd_err    = rd_err_q;
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic fl_ce_n,
    input logic fl_cle,
    input logic fl_ale,
    input logic fl_we_n,
    input logic fl_re_n,
    input logic fl_dq_oe,
    input logic fl_rdy
);
    AST_OE_OFF_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> !fl_dq_oe); // R8

    AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_re_n) |-> !fl_ce_n); // R4

    AST_CLE_HELD_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (fl_cle == $past(fl_cle))); // R4

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale)); // R5

    AST_RE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_re_n) |-> $past(fl_rdy)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R12
endmodule

bind nand_cycle_seq nand_cycle_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .fl_ce_n   (fl_ce_n),
    .fl_cle    (fl_cle),
    .fl_ale    (fl_ale),
    .fl_we_n   (fl_we_n),
    .fl_re_n   (fl_re_n),
    .fl_dq_oe  (fl_dq_oe),
    .fl_rdy    (fl_rdy)
);

// File: tb/nand_cycle_seq_test.sv
module nand_cycle_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_data = 8'h00;
    logic [15:0] req_page = 16'h0000;
    logic        hold_ce = 1'b0;
    logic [3:0]  cfg_pulse = 4'd2;
    logic [3:0]  cfg_hold = 4'd3;
    logic [15:0] cfg_timeout = 16'd100;
    logic        done;
    logic [7:0]  rd_data;
    logic        rd_err;
    logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
    logic [7:0]  fl_dq_out;
    logic [7:0]  fl_dq_in = 8'h00;
    logic        fl_rdy = 1'b1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // strobe monitor state
    int   w_cnt = 0;
    int   r_cnt = 0;
    int   w_run = 0;
    int   r_run = 0;
    int   w_len  [16];
    logic [7:0] w_byte [16];
    logic w_cle [16];
    logic w_ale [16];
    logic w_cle_after [16];
    int   r_len  [16];
    int   oe_gap = 0;
    int   ce_gap = 0;
    int   re_oe_bad = 0;
    int   re_busy = 0;
    logic prev_we = 1'b1;
    logic prev_re = 1'b1;
    logic [7:0] cur_byte;
    logic cur_cle, cur_ale;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_data(req_data), .req_page(req_page), .hold_ce(hold_ce),
        .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold), .cfg_timeout(cfg_timeout),
        .done(done), .rd_data(rd_data), .rd_err(rd_err),
        .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
        .fl_re_n(fl_re_n), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_rdy(fl_rdy)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (!fl_we_n) begin
                w_run = w_run + 1;
                cur_byte = fl_dq_out;
                cur_cle = fl_cle;
                cur_ale = fl_ale;
                if (!fl_dq_oe) oe_gap = oe_gap + 1;
                if (fl_ce_n) ce_gap = ce_gap + 1;
            end else if (!prev_we) begin
                w_len[w_cnt % 16] = w_run;
                w_byte[w_cnt % 16] = cur_byte;
                w_cle[w_cnt % 16] = cur_cle;
                w_ale[w_cnt % 16] = cur_ale;
                w_cle_after[w_cnt % 16] = fl_cle;
                w_cnt = w_cnt + 1;
                w_run = 0;
            end
            if (!fl_re_n) begin
                r_run = r_run + 1;
                if (fl_dq_oe) re_oe_bad = re_oe_bad + 1;
                if (!fl_rdy) re_busy = re_busy + 1;
            end else if (!prev_re) begin
                r_len[r_cnt % 16] = r_run;
                r_cnt = r_cnt + 1;
                r_run = 0;
            end
            prev_we = fl_we_n;
            prev_re = fl_re_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issue one request; lat = sample index of done, ready_busy = req_ready one sample after accept
    task automatic run_req(input logic [1:0] op, input logic [7:0] d, input logic [15:0] pg,
                           input logic hc, output int lat, output logic ready_busy);
        @(negedge clk);
        req_valid = 1'b1;
        req_op = op;
        req_data = d;
        req_page = pg;
        hold_ce = hc;
        @(negedge clk);
        req_valid = 1'b0;
        ready_busy = req_ready;
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        chk("R1 ce_n", fl_ce_n, 1);
        chk("R1 we_n", fl_we_n, 1);
        chk("R1 re_n", fl_re_n, 1);
        chk("R1 cle/ale/oe", {fl_cle, fl_ale, fl_dq_oe}, 0);
        chk("R1 done", done, 0);
        chk("R1 ready", req_ready, 1);
    endtask

    task automatic t_cmd_default();
        int lat; logic rb; int b;
        b = w_cnt;
        cfg_pulse = 4'd2; cfg_hold = 4'd3;
        run_req(2'd0, 8'h70, 16'h0, 1'b0, lat, rb);
        chk("R3 cmd latency", lat, 7);
        chk("R12 ready low while busy", rb, 0);
        chk("R2 cmd strobe count", w_cnt - b, 1);
        chk("R2 cmd WE width", w_len[b % 16], 2);
        chk("R4 cmd byte", w_byte[b % 16], 8'h70);
        chk("R4 CLE during WE", w_cle[b % 16], 1);
        chk("R4 ALE during WE", w_ale[b % 16], 0);
        chk("R4 CLE after WE rise", w_cle_after[b % 16], 1);
        @(negedge clk);
        chk("R12 done single pulse", done, 0);
        chk("R12 ready back", req_ready, 1);
        chk("R11 ce released", fl_ce_n, 1);
    endtask

    task automatic t_addr();
        int lat; logic rb; int b;
        b = w_cnt;
        cfg_pulse = 4'd1; cfg_hold = 4'd1;
        run_req(2'd1, 8'h12, 16'hBEEF, 1'b0, lat, rb);
        chk("R5 addr latency", lat, 8);
        chk("R5 addr strobe count", w_cnt - b, 3);
        chk("R5 column byte", w_byte[b % 16], 8'h12);
        chk("R5 page low byte", w_byte[(b+1) % 16], 8'hEF);
        chk("R5 page high byte", w_byte[(b+2) % 16], 8'hBE);
        chk("R5 ALE all strobes", {w_ale[b % 16], w_ale[(b+1) % 16], w_ale[(b+2) % 16]}, 7);
        chk("R5 CLE low", {w_cle[b % 16], w_cle[(b+1) % 16], w_cle[(b+2) % 16]}, 0);
        chk("R2 addr width", w_len[(b+2) % 16], 1);
    endtask

    task automatic t_write();
        int lat; logic rb; int b; int og;
        b = w_cnt; og = oe_gap;
        cfg_pulse = 4'd4; cfg_hold = 4'd2;
        run_req(2'd2, 8'hA5, 16'h0, 1'b0, lat, rb);
        chk("R3 write latency", lat, 8);
        chk("R2 write WE width", w_len[b % 16], 4);
        chk("R6 write byte", w_byte[b % 16], 8'hA5);
        chk("R6 oe through WE low", oe_gap - og, 0);
        chk("R6 no latch enables", {w_cle[b % 16], w_ale[b % 16]}, 0);
    endtask

    task automatic t_zero();
        int lat; logic rb; int b;
        b = w_cnt;
        cfg_pulse = 4'd0; cfg_hold = 4'd0;
        run_req(2'd0, 8'hFF, 16'h0, 1'b0, lat, rb);
        chk("R9 zero latency", lat, 4);
        chk("R9 zero width", w_len[b % 16], 1);
    endtask

    task automatic t_read_ready();
        int lat; logic rb; int b; int ob;
        b = r_cnt; ob = re_oe_bad;
        cfg_pulse = 4'd3; cfg_hold = 4'd2;
        fl_rdy = 1'b1; fl_dq_in = 8'h3C;
        run_req(2'd3, 8'h00, 16'h0, 1'b0, lat, rb);
        chk("R7 read latency", lat, 8);
        chk("R7 read data", rd_data, 8'h3C);
        chk("R7 read err", rd_err, 0);
        chk("R2 RE width", r_len[b % 16], 3);
        chk("R8 oe during RE", re_oe_bad - ob, 0);
    endtask

    task automatic t_read_busy();
        int lat; logic rb; int b; int bz;
        b = r_cnt; bz = re_busy;
        cfg_pulse = 4'd2; cfg_hold = 4'd2; cfg_timeout = 16'd50;
        fl_rdy = 1'b0; fl_dq_in = 8'hC3;
        fork
            run_req(2'd3, 8'h00, 16'h0, 1'b0, lat, rb);
            begin
                repeat (8) @(negedge clk);
                fl_rdy = 1'b1;
            end
        join
        chk("R7 no RE while busy", re_busy - bz, 0);
        chk("R7 one RE after ready", r_cnt - b, 1);
        chk("R7 busy read data", rd_data, 8'hC3);
        chk("R10 no error before limit", rd_err, 0);
    endtask

    task automatic t_timeout();
        int lat; logic rb; int b;
        b = r_cnt;
        cfg_timeout = 16'd5;
        fl_rdy = 1'b0;
        run_req(2'd3, 8'h00, 16'h0, 1'b0, lat, rb);
        chk("R10 timeout latency", lat, 7);
        chk("R10 error flag", rd_err, 1);
        chk("R10 no RE strobe", r_cnt - b, 0);
        fl_rdy = 1'b1;
    endtask

    task automatic t_hold_ce();
        int lat; logic rb;
        cfg_pulse = 4'd2; cfg_hold = 4'd2;
        run_req(2'd0, 8'h00, 16'h0, 1'b1, lat, rb);
        chk("R11 ce kept in done", fl_ce_n, 0);
        @(negedge clk);
        chk("R11 ce kept in idle", fl_ce_n, 0);
        run_req(2'd0, 8'h30, 16'h0, 1'b0, lat, rb);
        chk("R11 ce high in done", fl_ce_n, 1);
        @(negedge clk);
        chk("R11 ce high in idle", fl_ce_n, 1);
        chk("R4 ce low on every strobe", ce_gap, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_default();
        t_addr();
        t_write();
        t_zero();
        t_read_ready();
        t_read_busy();
        t_timeout();
        t_hold_ce();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule